// File: doc/BRIEF.md
# VBUS Window Supervisor and Discharge Timer

This block watches the digitized bus-rail voltage of a power-sourcing port and decides when the outgoing power path may be switched on. The supervisor stores the nominal voltage of the profile now in force. From it, the block derives an upper and a lower acceptance limit, each set by its own programmable percentage widening. It reports any reading that falls outside these limits. After every attach and every profile change it masks supervision for a programmable settling time. It then raises the path enable only when every enabled condition holds. A reading out of range while the path is on releases the path and requests error recovery.

The block also times the discharge output. A profile change to a lower voltage discharges the rail for the settling time. A detach or an error recovery discharges it for a separate, longer programmable time. All durations count a millisecond tick. Voltages are integer codes in 50 mV units. The analog front end, the discharge resistor and the profile negotiation are outside this block.

Top module: `vbus_guard`

## Requirements
- R1: The upper limit is nom + floor(nom*(5+shift_hi)/100). `over_flag` is 1 exactly when vbus_code is above the upper limit. Here nom is the stored nominal and shift_hi ranges from 0 to 15.
- R2: The lower limit is nom - floor(nom*(5+shift_lo)/100). `under_flag` is 1 exactly when vbus_code is below the lower limit. The stored nominal is loaded from nominal_code on every profile_chg pulse and on every attach.
- R3: An attach (a rising port_attached) or a profile_chg pulse while attached raises `blanking`. `blanking` stays high for max(blank_sel,1)*BLANK_STEP ticks of ms_tick.
- R4: A profile_chg while attached whose nominal_code is below the stored nominal drives the discharge output active for the same number of cycles as the blanking time. A change to an equal or higher voltage starts no discharge.
- R5: A detach, an err_recov pulse or an internal fault drives the discharge output active for max(zero_sel,1)*ZERO_STEP ticks.
- R6: `pwr_en_n` goes to 0 (path on) only under all of the following conditions. Otherwise it stays 1 (released):
  - the port is attached and was attached on the previous cycle, and the port is not blanking;
  - the VBUS reading is acceptable: within both limits when range_chk_en=1, or above vbus_uvlo_code when range_chk_en=0;
  - neither enabled supply flag is set (sup_uv_flag with sup_uv_chk_en, sup_ov_flag with sup_ov_chk_en).
- R7: Once the path is on, the supply flags have no effect, and only the VBUS reading is supervised.
- R8: An unacceptable reading before the path is on only withholds the path, with no error. An unacceptable reading outside blanking while the path is on releases the path and pulses `err_req` for one cycle. The path then stays off until the port detaches.
- R9: With dis_en=0 the discharge output holds its inactive level. The output is active low when dis_act_hi=0 and active high when dis_act_hi=1.
- R10: While blanking, the path state is held regardless of the VBUS reading, unless a detach or an err_recov occurs.
- R11: After reset: pwr_en_n=1, err_req=0, blanking=0, and the discharge output is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| vbus_code | input | VW | Measured rail voltage, 50 mV units |
| nominal_code | input | VW | Nominal voltage of the requested profile |
| profile_chg | input | 1 | Pulse: new profile takes effect |
| port_attached | input | 1 | Port attach level |
| err_recov | input | 1 | Pulse: external error recovery entry |
| shift_hi | input | SW | Upper limit widening, percent beyond 5 |
| shift_lo | input | SW | Lower limit widening, percent beyond 5 |
| range_chk_en | input | 1 | 1: window check, 0: undervoltage-only check |
| vbus_uvlo_code | input | VW | Undervoltage level for the undervoltage-only check |
| sup_uv_flag | input | 1 | Supply undervoltage detected |
| sup_ov_flag | input | 1 | Supply overvoltage detected |
| sup_uv_chk_en | input | 1 | Enable supply undervoltage lockout |
| sup_ov_chk_en | input | 1 | Enable supply overvoltage lockout |
| blank_sel | input | FW | Settling time in BLANK_STEP units (0 acts as 1) |
| zero_sel | input | FW | Discharge-to-zero time in ZERO_STEP units (0 acts as 1) |
| dis_en | input | 1 | Discharge enable |
| dis_act_hi | input | 1 | Discharge output polarity |
| pwr_en_n | output | 1 | Power path enable, 0 = on |
| dis_out | output | 1 | Discharge control |
| over_flag | output | 1 | Reading above upper limit |
| under_flag | output | 1 | Reading below lower limit |
| blanking | output | 1 | Supervision masked |
| err_req | output | 1 | One-cycle error recovery request |

## Verification
The bench builds the block with BLANK_STEP=2 and ZERO_STEP=3 and drives ms_tick on every cycle. With these values every settling and discharge window lasts a few cycles, so the bench can measure each one exactly as a count of cycles. For five nominal voltages it sweeps all sixteen values of both shift fields. At each setting it places the reading one code on either side of each computed limit, so every rounding boundary of the threshold arithmetic is exercised. With short windows, the sequencing cases also fit in a short run: profile rises and drops, faults, lockouts and polarity.

// File: rtl/vbg_pkg.sv
package vbg_pkg;
  localparam int BASE_PCT = 5;
  localparam int PCT_DIV  = 100;
endpackage

// File: rtl/vbg_window.sv
module vbg_window #(
  parameter int VW = 10,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [VW-1:0] nom,
  input  logic [SW-1:0] shift_hi,
  input  logic [SW-1:0] shift_lo,
  input  logic [VW-1:0] vbus,
  input  logic [VW-1:0] uvlo,
  output logic          over,
  output logic          under,
  output logic          above_uvlo
);
  import vbg_pkg::*;
  localparam int PW = VW + SW + 4;

  logic [PW-1:0] prod_hi, prod_lo, part_hi, part_lo;
  logic [VW:0]   thr_hi;
  logic [VW-1:0] thr_lo;

  always_comb begin
    prod_hi = PW'(nom) * (PW'(BASE_PCT) + PW'(shift_hi));
    prod_lo = PW'(nom) * (PW'(BASE_PCT) + PW'(shift_lo));
    part_hi = prod_hi / PW'(PCT_DIV);
    part_lo = prod_lo / PW'(PCT_DIV);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_hi     <= '1;
      thr_lo     <= '0;
      over       <= 1'b0;
      under      <= 1'b0;
      above_uvlo <= 1'b0;
    end else begin
      thr_hi     <= {1'b0, nom} + (VW+1)'(part_hi);
      thr_lo     <= nom - VW'(part_lo);
      over       <= {1'b0, vbus} > thr_hi;
      under      <= vbus < thr_lo;
      above_uvlo <= vbus > uvlo;
    end
  end
endmodule

// File: rtl/vbg_tmr.sv
module vbg_tmr #(
  parameter int FW   = 4,
  parameter int STEP = 20,
  localparam int CW  = $clog2(((1 << FW) - 1) * STEP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic [FW-1:0] sel,
  output logic          busy
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] steps;
  logic [CW-1:0] span;

  always_comb begin
    steps = (sel == '0) ? CW'(1) : CW'(sel);
    span  = steps * CW'(STEP);
  end

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= span;
    else if (tick && cnt != '0) cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/vbg_seq.sv
module vbg_seq #(
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          port_attached,
  input  logic          profile_chg,
  input  logic          err_recov,
  input  logic [VW-1:0] nominal_code,
  input  logic          over,
  input  logic          under,
  input  logic          above_uvlo,
  input  logic          range_chk_en,
  input  logic          sup_uv_flag,
  input  logic          sup_ov_flag,
  input  logic          sup_uv_chk_en,
  input  logic          sup_ov_chk_en,
  input  logic          blank_busy,
  input  logic          zero_busy,
  input  logic          dis_en,
  input  logic          dis_act_hi,
  output logic [VW-1:0] cur_nom,
  output logic          blank_load,
  output logic          zero_load,
  output logic          pwr_en_n,
  output logic          dis_out,
  output logic          err_req
);
  logic att_q, locked, drop_q;
  logic att_rise, detach, vbus_ok, supply_ok, fault, grant, dis_raw, drop_hit;

  always_comb begin
    att_rise   = port_attached && !att_q;
    detach     = att_q && !port_attached;
    vbus_ok    = range_chk_en ? (!over && !under) : above_uvlo;
    supply_ok  = !(sup_uv_chk_en && sup_uv_flag) && !(sup_ov_chk_en && sup_ov_flag);
    fault      = port_attached && att_q && !pwr_en_n && !blank_busy &&
                 !profile_chg && !err_recov && !vbus_ok;
    grant      = port_attached && att_q && pwr_en_n && !blank_busy &&
                 !locked && !profile_chg && vbus_ok && supply_ok;
    drop_hit   = profile_chg && port_attached && (nominal_code < cur_nom);
    blank_load = att_rise || (profile_chg && port_attached);
    zero_load  = detach || err_recov || fault;
    dis_raw    = zero_busy || (drop_q && blank_busy);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      att_q    <= 1'b0;
      locked   <= 1'b0;
      drop_q   <= 1'b0;
      cur_nom  <= '0;
      pwr_en_n <= 1'b1;
      err_req  <= 1'b0;
      dis_out  <= !dis_act_hi;
    end else begin
      att_q   <= port_attached;
      err_req <= fault;
      if (profile_chg || att_rise) cur_nom <= nominal_code;

      if (!port_attached)            locked <= 1'b0;
      else if (fault || err_recov)   locked <= 1'b1;

      if (drop_hit)                  drop_q <= 1'b1;
      else if (zero_load || !blank_busy) drop_q <= 1'b0;

      if (!port_attached || err_recov || fault) pwr_en_n <= 1'b1;
      else if (grant)                           pwr_en_n <= 1'b0;

      dis_out <= (dis_en && dis_raw) ? dis_act_hi : !dis_act_hi;
    end
  end
endmodule

// File: rtl/vbus_guard.sv
module vbus_guard #(
  parameter int VW         = 10,
  parameter int SW         = 4,
  parameter int FW         = 4,
  parameter int BLANK_STEP = 20,
  parameter int ZERO_STEP  = 84
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ms_tick,
  input  logic [VW-1:0] vbus_code,
  input  logic [VW-1:0] nominal_code,
  input  logic          profile_chg,
  input  logic          port_attached,
  input  logic          err_recov,
  input  logic [SW-1:0] shift_hi,
  input  logic [SW-1:0] shift_lo,
  input  logic          range_chk_en,
  input  logic [VW-1:0] vbus_uvlo_code,
  input  logic          sup_uv_flag,
  input  logic          sup_ov_flag,
  input  logic          sup_uv_chk_en,
  input  logic          sup_ov_chk_en,
  input  logic [FW-1:0] blank_sel,
  input  logic [FW-1:0] zero_sel,
  input  logic          dis_en,
  input  logic          dis_act_hi,
  output logic          pwr_en_n,
  output logic          dis_out,
  output logic          over_flag,
  output logic          under_flag,
  output logic          blanking,
  output logic          err_req
);
  logic [VW-1:0] cur_nom;
  logic above_uvlo, blank_load, zero_load, blank_busy, zero_busy;

  vbg_window #(.VW(VW), .SW(SW)) u_win (
    .clk(clk), .rst(rst), .nom(cur_nom), .shift_hi(shift_hi), .shift_lo(shift_lo),
    .vbus(vbus_code), .uvlo(vbus_uvlo_code),
    .over(over_flag), .under(under_flag), .above_uvlo(above_uvlo)
  );

  vbg_tmr #(.FW(FW), .STEP(BLANK_STEP)) u_blank (
    .clk(clk), .rst(rst), .tick(ms_tick), .load(blank_load), .sel(blank_sel),
    .busy(blank_busy)
  );

  vbg_tmr #(.FW(FW), .STEP(ZERO_STEP)) u_zero (
    .clk(clk), .rst(rst), .tick(ms_tick), .load(zero_load), .sel(zero_sel),
    .busy(zero_busy)
  );

  vbg_seq #(.VW(VW)) u_seq (
    .clk(clk), .rst(rst), .port_attached(port_attached), .profile_chg(profile_chg),
    .err_recov(err_recov), .nominal_code(nominal_code),
    .over(over_flag), .under(under_flag), .above_uvlo(above_uvlo),
    .range_chk_en(range_chk_en), .sup_uv_flag(sup_uv_flag), .sup_ov_flag(sup_ov_flag),
    .sup_uv_chk_en(sup_uv_chk_en), .sup_ov_chk_en(sup_ov_chk_en),
    .blank_busy(blank_busy), .zero_busy(zero_busy),
    .dis_en(dis_en), .dis_act_hi(dis_act_hi),
    .cur_nom(cur_nom), .blank_load(blank_load), .zero_load(zero_load),
    .pwr_en_n(pwr_en_n), .dis_out(dis_out), .err_req(err_req)
  );

  assign blanking = blank_busy;
endmodule

// File: rtl/vbg_chk.sv
module vbg_chk (
  input logic clk,
  input logic rst,
  input logic port_attached,
  input logic err_recov,
  input logic dis_en,
  input logic dis_act_hi,
  input logic pwr_en_n,
  input logic dis_out,
  input logic blanking,
  input logic err_req
);
  AST_DETACH_RELEASES: assert property (@(posedge clk) disable iff (rst)
    !port_attached |=> pwr_en_n); // R6

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    err_req |=> !err_req); // R8

  AST_ERR_WITH_RELEASE: assert property (@(posedge clk) disable iff (rst)
    err_req |-> pwr_en_n); // R8

  AST_DIS_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !dis_en |=> (dis_out == !$past(dis_act_hi))); // R9

  AST_PATH_HELD_BLANK: assert property (@(posedge clk) disable iff (rst)
    (blanking && port_attached && !err_recov) |=> $stable(pwr_en_n)); // R10
endmodule

bind vbus_guard vbg_chk u_chk (
  .clk(clk), .rst(rst), .port_attached(port_attached), .err_recov(err_recov),
  .dis_en(dis_en), .dis_act_hi(dis_act_hi), .pwr_en_n(pwr_en_n),
  .dis_out(dis_out), .blanking(blanking), .err_req(err_req)
);

// File: tb/test_vbus_guard.sv
`timescale 1ns/1ps
module test_vbus_guard;
  localparam int VW = 10, SW = 4, FW = 4, BS = 2, ZS = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic ms_tick = 1'b1;
  logic [VW-1:0] vbus_code = '0, nominal_code = '0, vbus_uvlo_code = 10'd80;
  logic profile_chg = 0, port_attached = 0, err_recov = 0;
  logic [SW-1:0] shift_hi = 4'd5, shift_lo = 4'd5;
  logic range_chk_en = 1, sup_uv_flag = 0, sup_ov_flag = 0, sup_uv_chk_en = 0, sup_ov_chk_en = 0;
  logic [FW-1:0] blank_sel = 4'd3, zero_sel = 4'd0;
  logic dis_en = 1, dis_act_hi = 0;
  logic pwr_en_n, dis_out, over_flag, under_flag, blanking, err_req;

  int n_chk = 0, n_bad = 0;
  int nb, nd, ne, np;
  bit done = 0;

  always #2 clk = ~clk;

  vbus_guard #(.VW(VW), .SW(SW), .FW(FW), .BLANK_STEP(BS), .ZERO_STEP(ZS)) i_vbus_guard (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .vbus_code(vbus_code),
    .nominal_code(nominal_code), .profile_chg(profile_chg), .port_attached(port_attached),
    .err_recov(err_recov), .shift_hi(shift_hi), .shift_lo(shift_lo),
    .range_chk_en(range_chk_en), .vbus_uvlo_code(vbus_uvlo_code),
    .sup_uv_flag(sup_uv_flag), .sup_ov_flag(sup_ov_flag),
    .sup_uv_chk_en(sup_uv_chk_en), .sup_ov_chk_en(sup_ov_chk_en),
    .blank_sel(blank_sel), .zero_sel(zero_sel), .dis_en(dis_en), .dis_act_hi(dis_act_hi),
    .pwr_en_n(pwr_en_n), .dis_out(dis_out), .over_flag(over_flag),
    .under_flag(under_flag), .blanking(blanking), .err_req(err_req)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts blanking, active discharge, err_req and released-path cycles
  task automatic watch(input int win);
    nb = 0; nd = 0; ne = 0; np = 0;
    for (int i = 0; i < win; i++) begin
      if (blanking) nb++;
      if (dis_out == dis_act_hi) nd++;
      if (err_req) ne++;
      if (pwr_en_n) np++;
      @(negedge clk);
    end
  endtask

  task automatic new_profile(input int nom);
    nominal_code = VW'(nom);
    profile_chg = 1'b1;
    step(1);
    profile_chg = 1'b0;
  endtask

  initial begin
    int noms[5] = '{100, 180, 240, 300, 400};
    int hi, lo;
    step(3);
    // R11 reset state
    chk("R11 pwr_en_n", pwr_en_n, 1);
    chk("R11 dis_out", dis_out, 1);
    chk("R11 err_req", err_req, 0);
    chk("R11 blanking", blanking, 0);
    rst = 1'b0;
    step(2);

    // R1/R2 threshold sweep, detached
    foreach (noms[k]) begin
      for (int s = 0; s < 16; s++) begin
        shift_hi = SW'(s);
        shift_lo = SW'(15 - s);
        new_profile(noms[k]);
        step(3);
        hi = noms[k] + noms[k] * (5 + s) / 100;
        lo = noms[k] - noms[k] * (20 - s) / 100;
        vbus_code = VW'(hi);     step(3); chk("R1 at upper limit", over_flag, 0);
        vbus_code = VW'(hi + 1); step(3); chk("R1 above upper limit", over_flag, 1);
        vbus_code = VW'(lo);     step(3); chk("R2 at lower limit", under_flag, 0);
        vbus_code = VW'(lo - 1); step(3); chk("R2 below lower limit", under_flag, 1);
      end
    end

    // attach, nominal 100, limits 110/90
    shift_hi = 4'd5; shift_lo = 4'd5;
    nominal_code = 10'd100; vbus_code = 10'd100;
    step(2);
    port_attached = 1'b1;
    watch(20);
    chk("R3 attach blank cycles", nb, 6);
    chk("R4 no discharge on attach", nd, 0);
    chk("R6 path on after blank", pwr_en_n, 0);

    new_profile(180);
    vbus_code = 10'd180;
    watch(20);
    chk("R3 profile blank cycles", nb, 6);
    chk("R4 rise no discharge", nd, 0);
    chk("R10 path held in blank", np, 0);

    new_profile(100);
    vbus_code = 10'd100;
    watch(20);
    chk("R4 drop discharge cycles", nd, 6);
    chk("R10 path held on drop", np, 0);

    blank_sel = 4'd0;
    new_profile(100);
    watch(20);
    chk("R3 zero field blank cycles", nb, 2);
    chk("R4 equal no discharge", nd, 0);

    sup_uv_chk_en = 1'b1; sup_uv_flag = 1'b1;
    step(6);
    chk("R7 supply flag ignored when on", pwr_en_n, 0);
    sup_uv_flag = 1'b0;

    vbus_code = 10'd150;
    watch(20);
    chk("R8 err pulse count", ne, 1);
    chk("R5 fault discharge cycles", nd, 3);
    chk("R8 path released", pwr_en_n, 1);
    vbus_code = 10'd100;
    step(10);
    chk("R8 locked until detach", pwr_en_n, 1);

    port_attached = 1'b0;
    step(10);
    sup_uv_flag = 1'b1;
    port_attached = 1'b1;
    step(20);
    chk("R6 supply lockout blocks", pwr_en_n, 1);
    sup_uv_chk_en = 1'b0;
    step(4);
    chk("R6 lockout disabled enables", pwr_en_n, 0);
    sup_uv_flag = 1'b0;

    zero_sel = 4'd2;
    port_attached = 1'b0;
    watch(20);
    chk("R5 detach discharge cycles", nd, 6);
    chk("R6 detach releases", pwr_en_n, 1);

    vbus_code = 10'd150;
    port_attached = 1'b1;
    watch(20);
    chk("R8 blocked at attach no err", ne, 0);
    chk("R8 blocked at attach path off", pwr_en_n, 1);
    vbus_code = 10'd100;
    step(4);
    chk("R8 attach path after recovery", pwr_en_n, 0);

    range_chk_en = 1'b0;
    vbus_code = 10'd150;
    step(6);
    chk("R6 range off accepts above uvlo", pwr_en_n, 0);
    vbus_code = 10'd70;
    watch(20);
    chk("R6 range off uvlo fault err", ne, 1);
    chk("R5 uvlo fault discharge", nd, 6);
    chk("R6 range off release", pwr_en_n, 1);
    range_chk_en = 1'b1;
    vbus_code = 10'd100;
    port_attached = 1'b0;
    step(20);

    port_attached = 1'b1;
    step(20);
    chk("R6 path on before recovery", pwr_en_n, 0);
    err_recov = 1'b1;
    step(1);
    err_recov = 1'b0;
    watch(20);
    chk("R5 err_recov discharge", nd, 6);
    chk("R5 err_recov releases", pwr_en_n, 1);
    chk("R8 no err_req for external", ne, 0);
    port_attached = 1'b0;
    step(20);

    dis_en = 1'b0;
    port_attached = 1'b1;
    step(20);
    port_attached = 1'b0;
    watch(20);
    chk("R9 disabled discharge", nd, 0);
    dis_en = 1'b1;
    dis_act_hi = 1'b1;
    step(2);
    chk("R9 active-high idle", dis_out, 0);
    port_attached = 1'b1;
    step(20);
    port_attached = 1'b0;
    watch(20);
    chk("R9 active-high discharge", nd, 6);

    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule